// File: doc/BRIEF.md
# Programmable master clock prescaler

This block turns a fast input clock into a slower tick stream. The tick runs at a rate set by two 3-bit codes taken from a configuration word. The first code is a prescaler that divides by a power of two. A parameter can reassign its top code to mean divide by three. The second code indexes a small divisor table held in a parameter. That table forms a post-divider chained behind the prescaler. The block drives two single-cycle enable pulses. One marks each prescaler period. The other marks each full output period, which lasts prescaler ratio times post-divider ratio input cycles.

The configuration word comes from a register outside the block. A parameter mask clears unused bits before either field is read. The prescaler field's bit offset is a parameter, and the post-divider field sits at a fixed position.

A change of codes is held back until the current output period ends, so no short period is ever produced. A ready flag drops while a change is pending and comes back once the new ratio is in force. A channel-number parameter decides which of two ready pins carries that flag. All pins are plain control and status lines. No data flows through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `mck_prescaler`

## Requirements
- R1: Synchronous active-high reset loads both active codes as 0, giving a total ratio of 1. In the first cycle after reset, `out_tick` is high in every cycle (while the word asks for codes 0) and the channel's ready pin is high.
- R2: Prescaler code n, for n from 0 to 6, makes `pre_tick` pulse once every 2^n input cycles.
- R3: Prescaler code 7 selects ratio 3 when `DIV3_EN` is 1. It selects ratio 128 when `DIV3_EN` is 0.
- R4: The prescaler code is read from bits `PRE_POS+2:PRE_POS` of the masked word, and offsets 2 and 4 both work.
- R5: The post-divider code is read from bits 10:8 of the masked word. It picks byte k of `POST_TABLE` (bits 8k+7:8k), and a table entry of 0 acts as 1. `out_tick` pulses once every prescaler ratio times post ratio input cycles.
- R6: Word bits that are 0 in `CFG_MASK` have no effect: neither the tick period nor the ready pin changes when they toggle.
- R7: New codes take effect only at the edge that ends an output period. The last tick at the old ratio lands exactly where the old ratio puts it, and the first tick at the new ratio follows one full new period later.
- R8: When the requested codes differ from the active ones in a cycle without `out_tick`, ready is low from the next cycle on. It rises in the cycle after the `out_tick` at which the new codes are loaded.
- R9: With `CHANNEL_ID` equal to 0, the ready flag appears on `rdy_main` and `rdy_aux` is held low. With any other `CHANNEL_ID`, the flag appears on `rdy_aux` and `rdy_main` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | CFG_W | Configuration word from the register that holds the codes |
| pre_tick | output | 1 | One-cycle pulse at the end of each prescaler period |
| out_tick | output | 1 | One-cycle pulse at the end of each full output period |
| rdy_main | output | 1 | Ready flag when CHANNEL_ID is 0, otherwise low |
| rdy_aux | output | 1 | Ready flag when CHANNEL_ID is not 0, otherwise low |

## Verification
A wrong count limit or a mis-decoded code shows up as a tick spacing that is off from the very next period. The bench therefore measures the gap between consecutive pulses for every prescaler code and for several table entries. If the active codes load at the wrong moment, the last old-ratio tick lands early, or ready rises one or more cycles off. Both effects appear within one old period after the word changes. A wrong mask or field offset shows as a changed period, or as a ready drop within one cycle of toggling an ignored bit.

// File: rtl/mck_pkg.sv
package mck_pkg;
  localparam int CODE_W = 3;
  localparam int N_CODES = 1 << CODE_W;
  typedef logic [CODE_W-1:0] code_t;
  typedef struct packed {
    code_t pre;
    code_t post;
  } codes_t;
endpackage

// File: rtl/mck_pre_decode.sv
module mck_pre_decode
  import mck_pkg::*;
#(
  parameter bit DIV3_EN = 1'b1,
  parameter int RATIO_W = 8
) (
  input  code_t              code,
  output logic [RATIO_W-1:0] ratio
);
  localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};
  localparam logic [RATIO_W-1:0] THREE = ONE + ONE + ONE;

  generate
    if (DIV3_EN) begin : g_div3
      always_comb ratio = (code == code_t'(N_CODES - 1)) ? THREE : (ONE << code);
    end else begin : g_pow2
      always_comb ratio = ONE << code;
    end
  endgenerate
endmodule

// File: rtl/mck_post_lut.sv
module mck_post_lut
  import mck_pkg::*;
#(
  parameter int ENTRY_W = 8,
  parameter logic [N_CODES*ENTRY_W-1:0] TABLE = '0
) (
  input  code_t              code,
  output logic [ENTRY_W-1:0] ratio
);
  logic [ENTRY_W-1:0] tbl [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_ent
    localparam logic [ENTRY_W-1:0] RAW = TABLE[g*ENTRY_W +: ENTRY_W];
    assign tbl[g] = (RAW == '0) ? ENTRY_W'(1) : RAW;
  end

  assign ratio = tbl[code];
endmodule

// File: rtl/mck_div_chain.sv
module mck_div_chain #(
  parameter int PRE_W = 8,
  parameter int POST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PRE_W-1:0]  pre_ratio,
  input  logic [POST_W-1:0] post_ratio,
  output logic              pre_tick,
  output logic              out_tick
);
  logic [PRE_W-1:0]  pcnt;
  logic [POST_W-1:0] qcnt;
  logic [PRE_W-1:0]  pre_last;
  logic [POST_W-1:0] post_last;

  assign pre_last  = pre_ratio - PRE_W'(1);
  assign post_last = post_ratio - POST_W'(1);
  assign pre_tick  = (pcnt == pre_last);
  assign out_tick  = pre_tick && (qcnt == post_last);

  always_ff @(posedge clk) begin
    if (rst || out_tick) begin
      pcnt <= '0;
      qcnt <= '0;
    end else if (pre_tick) begin
      pcnt <= '0;
      qcnt <= qcnt + POST_W'(1);
    end else begin
      pcnt <= pcnt + PRE_W'(1);
    end
  end

  assert_pcnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    pcnt < pre_ratio);
  assert_qcnt_range_R5: assert property (@(posedge clk) disable iff (rst)
    qcnt < post_ratio);
endmodule

// File: rtl/mck_prescaler.sv
module mck_prescaler
  import mck_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter logic [CFG_W-1:0] CFG_MASK = 32'h0000_0770,
  parameter int PRE_POS = 4,
  parameter int POST_POS = 8,
  parameter bit DIV3_EN = 1'b1,
  parameter int CHANNEL_ID = 0,
  parameter int ENTRY_W = 8,
  parameter logic [N_CODES*ENTRY_W-1:0] POST_TABLE = 64'h00_01_01_05_03_04_02_01
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             pre_tick,
  output logic             out_tick,
  output logic             rdy_main,
  output logic             rdy_aux
);
  localparam int PRE_RATIO_W = N_CODES + 1;

  logic [CFG_W-1:0]       masked;
  codes_t                 req;
  codes_t                 act_q;
  logic                   rdy_q;
  logic [PRE_RATIO_W-1:0] pre_ratio;
  logic [ENTRY_W-1:0]     post_ratio;
  logic                   pending;

  assign masked   = cfg_word & CFG_MASK;
  assign req.pre  = masked[PRE_POS +: CODE_W];
  assign req.post = masked[POST_POS +: CODE_W];
  assign pending  = (req != act_q);

  mck_pre_decode #(.DIV3_EN(DIV3_EN), .RATIO_W(PRE_RATIO_W)) u_pre (
    .code(act_q.pre), .ratio(pre_ratio));

  mck_post_lut #(.ENTRY_W(ENTRY_W), .TABLE(POST_TABLE)) u_post (
    .code(act_q.post), .ratio(post_ratio));

  mck_div_chain #(.PRE_W(PRE_RATIO_W), .POST_W(ENTRY_W)) u_chain (
    .clk(clk), .rst(rst), .pre_ratio(pre_ratio), .post_ratio(post_ratio),
    .pre_tick(pre_tick), .out_tick(out_tick));

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
      rdy_q <= 1'b1;
    end else if (out_tick) begin
      act_q <= req;
      rdy_q <= 1'b1;
    end else if (pending) begin
      rdy_q <= 1'b0;
    end
  end

  generate
    if (CHANNEL_ID == 0) begin : g_ch_main
      assign rdy_main = rdy_q;
      assign rdy_aux  = 1'b0;
    end else begin : g_ch_aux
      assign rdy_main = 1'b0;
      assign rdy_aux  = rdy_q;
    end
  endgenerate

  assert_apply_at_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_q) |-> $past(out_tick));
  assert_ready_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(out_tick));
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (pending && !out_tick) |=> !rdy_q);
endmodule

// File: tb/test_mck_prescaler.sv
module test_mck_prescaler;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] a_cfg = '0;
  logic [31:0] b_cfg = '0;
  logic a_pre, a_out, a_rm, a_ra;
  logic b_pre, b_out, b_rm, b_ra;
  int checks = 0;
  int errors = 0;
  bit sel = 1'b0;
  logic mon_out, mon_pre, mon_rdy;

  always #2.5 clk = ~clk;

  mck_prescaler i_mck_prescaler (
    .clk(clk), .rst(rst), .cfg_word(a_cfg),
    .pre_tick(a_pre), .out_tick(a_out), .rdy_main(a_rm), .rdy_aux(a_ra));

  mck_prescaler #(.CFG_MASK(32'h0000_071C), .PRE_POS(2), .DIV3_EN(1'b0),
                  .CHANNEL_ID(1)) i_mck_prescaler_b (
    .clk(clk), .rst(rst), .cfg_word(b_cfg),
    .pre_tick(b_pre), .out_tick(b_out), .rdy_main(b_rm), .rdy_aux(b_ra));

  always_comb begin
    mon_out = sel ? b_out : a_out;
    mon_pre = sel ? b_pre : a_pre;
    mon_rdy = sel ? b_ra : a_rm;
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wait_out();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (mon_out) break;
    end
  endtask

  task automatic period(input bit use_pre, output int n);
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (use_pre ? mon_pre : mon_out) break;
    end
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (use_pre ? mon_pre : mon_out) break;
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    if (sel) b_cfg = w; else a_cfg = w;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (mon_rdy) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready A", int'(a_rm), 1);
    chk("R1 tick A", int'(a_out), 1);
    chk("R9 aux low A", int'(a_ra), 0);
    chk("R9 ready B on aux", int'(b_ra), 1);
    chk("R9 main low B", int'(b_rm), 0);
    @(negedge clk);
    chk("R1 tick every cycle", int'(a_out), 1);
  endtask

  task automatic t_pow2();
    int n;
    sel = 1'b0;
    for (int c = 0; c < 7; c++) begin
      apply(32'(c) << 4);
      period(1'b1, n);
      chk($sformatf("R2 code %0d", c), n, 1 << c);
    end
    apply(32'h70);
    period(1'b1, n);
    chk("R3 div3 on", n, 3);
  endtask

  task automatic t_offset_b();
    int n;
    sel = 1'b1;
    apply(32'h3 << 2);
    period(1'b0, n);
    chk("R4 offset 2 code 3", n, 8);
    apply(32'h7 << 2);
    period(1'b0, n);
    chk("R3 div3 off gives 128", n, 128);
    chk("R9 main stays low", int'(b_rm), 0);
    apply(32'h0);
    sel = 1'b0;
  endtask

  task automatic t_post();
    int n;
    sel = 1'b0;
    apply(32'h0000_0310);
    period(1'b0, n);
    chk("R5 pre2 x entry3", n, 6);
    period(1'b1, n);
    chk("R5 pre tick inside", n, 2);
    apply(32'h0000_0410);
    period(1'b0, n);
    chk("R5 pre2 x entry4", n, 10);
    apply(32'h0000_0700);
    period(1'b0, n);
    chk("R5 zero entry acts as 1", n, 1);
  endtask

  task automatic t_mask();
    int n;
    int drops;
    sel = 1'b0;
    apply(32'h0000_0020);
    drops = 0;
    @(negedge clk);
    a_cfg = 32'hFFFF_F88F | 32'h20;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!a_rm) drops++;
    end
    chk("R6 ready unaffected", drops, 0);
    period(1'b0, n);
    chk("R6 period unaffected", n, 4);
    sel = 1'b1;
    apply(32'h0000_0008);
    @(negedge clk);
    b_cfg = 32'hFFFF_F8E3 | 32'h8;
    drops = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!b_ra) drops++;
    end
    chk("R6 B ready unaffected", drops, 0);
    period(1'b0, n);
    chk("R6 B period unaffected", n, 4);
    sel = 1'b0;
  endtask

  task automatic t_change();
    int n;
    int rise_at;
    int old_tick;
    int new_tick;
    sel = 1'b0;
    apply(32'h20);
    wait_out();
    @(negedge clk);
    a_cfg = 32'h30;
    rise_at = 0; old_tick = 0; new_tick = 0;
    for (int i = 1; i < 40; i++) begin
      @(negedge clk);
      if (i == 1) chk("R8 ready drops", int'(a_rm), 0);
      if (a_out && old_tick == 0) old_tick = i;
      else if (a_out && new_tick == 0) new_tick = i;
      if (a_rm && rise_at == 0) rise_at = i;
    end
    chk("R7 last old tick", old_tick, 3);
    chk("R8 ready rise cycle", rise_at, 4);
    chk("R7 first new period", new_tick - old_tick, 8);
    period(1'b0, n);
    chk("R7 new ratio steady", n, 8);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pow2();
    t_offset_b();
    t_post();
    t_mask();
    t_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule